// File: doc/BRIEF.md
# Sampled Constant-Fraction Timing Discriminator

This block finds the arrival time of negative-going pulses in a stream of signed detector samples, one sample per clock. From the input it builds a bipolar shaped signal: the input from a selectable number of samples back, minus roughly one fifth of the current input. The time of a pulse is where that shaped signal passes from non-negative to negative. A leading-edge comparator against a lower-level threshold must arm the crossing detector first, so small pulses and noise are rejected.

One of three timing modes is selected at a time. Plain constant fraction reports the shaped-signal crossing. If the arm comes late, it reports the arming sample instead. Slow-rise reject discards such late-armed pulses. Leading edge reports the threshold crossing itself. Each reported event gives a one-cycle strobe and a 6-bit sub-sample fraction. That fraction comes from linear interpolation between the two samples that bracket the crossing, computed in a pipelined restoring divider.

Top module: `cfd_timer`

## Requirements
- R1: While reset is high and in the first cycle after it, `strobe` is 0 and `frac` is 0.
- R2: The shaped value for sample n is s[n] = x[n-D] - (floor(x[n]/8) + floor(x[n]/16) + floor(x[n]/128)). Here D = `dly_sel` + 1, which covers 1 to 64 samples. Samples before reset count as 0.
- R3: A sample with x < `thresh` (signed compare) arms the detector, provided the input has been at or above `thresh` since the last arming. While the detector is not armed, a shaped crossing gives no strobe.
- R4: In mode 2'b00, and also 2'b11, a zero crossing gives a strobe. A zero crossing is s[n-1] >= 0 and s[n] < 0, seen on an armed sample or on the arming sample. If the arming sample has s < 0 without being a crossing, the strobe is given for that sample with fraction 0.
- R5: In mode 2'b01 only a zero crossing seen on an armed sample or on the arming sample gives a strobe. An arming sample whose shaped value is already negative, without a crossing, gives no strobe and does not arm.
- R6: In mode 2'b10 the strobe is given for the sample where the input first drops below `thresh`, with fraction 0. The shaped signal plays no part.
- R7: For a zero-crossing event, `frac` = floor(64 * s[n-1] / (s[n-1] - s[n])).
- R8: The strobe for sample n is high for one cycle, FW = 6 clock edges after the edge that captures sample n. While `strobe` is low, `frac` is 0.
- R9: A strobe disarms the detector. The next arm needs the input to have been back at or above `thresh` first.
- R10: An arm lasts for the arming sample and the next TOUT samples (parameter, default 255). A crossing later than that gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | DW (12) | Signed input sample |
| thresh | input | DW (12) | Signed lower-level threshold, negative |
| dly_sel | input | 6 | Shaping delay minus one |
| mode | input | 2 | 00/11 constant fraction, 01 slow-rise reject, 10 leading edge |
| strobe | output | 1 | One-cycle event strobe |
| frac | output | FW (6) | Sub-sample crossing fraction, in 1/64 of a sample |

## Verification
Fast steps of several amplitudes and delays check the constant-fraction crossing and its interpolated fraction in the constant-fraction and reject modes. The two modes agree on these steps. A slow linear ramp that crosses the threshold well after the shaped signal has gone negative separates the three modes: constant fraction fires late, the reject mode stays silent, and leading edge fires at the threshold sample. A pulse below threshold, a long held pulse, a double pulse, and steps whose delay sits on either side of the arm timeout check arming, re-arming and the timeout window.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

  typedef enum logic [1:0] {
    MODE_CF     = 2'b00,
    MODE_SRT    = 2'b01,
    MODE_LE     = 2'b10,
    MODE_CF_ALT = 2'b11
  } cfd_mode_e;

  // Fraction close to 0.2 formed from three arithmetic shifts (floor rounding).
  function automatic logic signed [31:0] cf_scale(input logic signed [31:0] v);
    return (v >>> 3) + (v >>> 4) + (v >>> 7);
  endfunction

  // Zero crossing of the shaped signal: previous non-negative, current negative.
  function automatic logic cf_cross(input logic prev_neg, input logic cur_neg);
    return !prev_neg && cur_neg;
  endfunction

endpackage

// File: rtl/cfd_delay_line.sv
module cfd_delay_line #(
  parameter int DW    = 12,
  parameter int DEPTH = 64,
  parameter int SELW  = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] din,
  input  logic [SELW-1:0]      sel,
  output logic signed [DW-1:0] now_q,
  output logic signed [DW-1:0] dly_q
);
  localparam int IW = SELW + 1;

  logic signed [DW-1:0] tap [DEPTH+1];
  logic [IW-1:0]        idx;

  always_ff @(posedge clk) begin
    if (rst) tap[0] <= '0;
    else     tap[0] <= din;
  end

  for (genvar i = 1; i <= DEPTH; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) tap[i] <= '0;
      else     tap[i] <= tap[i-1];
    end
  end

  assign idx   = {1'b0, sel} + IW'(1);
  assign now_q = tap[0];
  assign dly_q = tap[idx];
endmodule

// File: rtl/cfd_arm_ctrl.sv
module cfd_arm_ctrl
  import cfd_pkg::*;
#(
  parameter int DW   = 12,
  parameter int SW   = 14,
  parameter int TOUT = 255,
  parameter int TMW  = 8,
  localparam int RW  = SW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] x_now,
  input  logic signed [DW-1:0] thresh,
  input  logic signed [SW-1:0] s_cur,
  input  logic signed [SW-1:0] s_prev,
  input  logic [1:0]           mode,
  output logic                 hit,
  output logic                 zc,
  output logic                 arm_now,
  output logic                 armed,
  output logic                 rearm_ok,
  output logic [TMW-1:0]       tmo_cnt,
  output logic [RW-1:0]        num,
  output logic [RW-1:0]        den
);
  cfd_mode_e          md;
  logic               below, late, arm_set, use_interp;
  logic signed [SW:0] diff;

  always_comb begin
    md      = cfd_mode_e'(mode);
    below   = x_now < thresh;
    arm_now = rearm_ok && below;
    zc      = cf_cross(s_prev[SW-1], s_cur[SW-1]);
    late    = arm_now && s_cur[SW-1] && !zc;
    unique case (md)
      MODE_LE:  hit = arm_now;
      MODE_SRT: hit = (armed || arm_now) && zc;
      default:  hit = ((armed || arm_now) && zc) || late;
    endcase
    arm_set    = arm_now && !hit && !(md == MODE_SRT && late);
    use_interp = zc && (md != MODE_LE);
    diff       = {s_prev[SW-1], s_prev} - {s_cur[SW-1], s_cur};
    num        = use_interp ? {2'b00, s_prev} : '0;
    den        = use_interp ? {1'b0, diff} : RW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      tmo_cnt  <= '0;
      rearm_ok <= 1'b0;
    end else begin
      if (hit) begin
        armed <= 1'b0;
      end else if (arm_set) begin
        armed   <= 1'b1;
        tmo_cnt <= '0;
      end else if (armed) begin
        if (tmo_cnt == TMW'(TOUT - 1)) armed <= 1'b0;
        else                           tmo_cnt <= tmo_cnt + 1'b1;
      end
      if (!below)       rearm_ok <= 1'b1;
      else if (arm_now) rearm_ok <= 1'b0;
    end
  end
endmodule

// File: rtl/cfd_interp.sv
module cfd_interp #(
  parameter int SW = 14,
  parameter int FW = 6,
  localparam int RW = SW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [RW-1:0] num,
  input  logic [RW-1:0] den,
  output logic          done,
  output logic [FW-1:0] quo
);
  logic [RW-1:0] rem_s [FW+1];
  logic [RW-1:0] den_s [FW+1];
  logic [FW-1:0] quo_s [FW+1];
  logic          vld_s [FW+1];

  assign rem_s[0] = num;
  assign den_s[0] = den;
  assign quo_s[0] = '0;
  assign vld_s[0] = start;

  for (genvar j = 0; j < FW; j++) begin : g_stage
    logic [RW-1:0] shl;
    logic          ge;
    always_comb begin
      shl = {rem_s[j][RW-2:0], 1'b0};
      ge  = shl >= den_s[j];
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_s[j+1] <= 1'b0;
        rem_s[j+1] <= '0;
        den_s[j+1] <= '0;
        quo_s[j+1] <= '0;
      end else begin
        vld_s[j+1] <= vld_s[j];
        rem_s[j+1] <= ge ? shl - den_s[j] : shl;
        den_s[j+1] <= den_s[j];
        quo_s[j+1] <= {quo_s[j][FW-2:0], ge};
      end
    end
  end

  assign done = vld_s[FW];
  assign quo  = vld_s[FW] ? quo_s[FW] : '0;
endmodule

// File: rtl/cfd_timer.sv
module cfd_timer
  import cfd_pkg::*;
#(
  parameter int DW        = 12,
  parameter int MAX_DELAY = 64,
  parameter int FW        = 6,
  parameter int TOUT      = 255,
  localparam int SELW     = $clog2(MAX_DELAY),
  localparam int SW       = DW + 2,
  localparam int RW       = SW + 2,
  localparam int TMW      = $clog2(TOUT + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] sample_in,
  input  logic signed [DW-1:0] thresh,
  input  logic [SELW-1:0]      dly_sel,
  input  logic [1:0]           mode,
  output logic                 strobe,
  output logic [FW-1:0]        frac
);
  logic signed [DW-1:0] x_now, x_del;
  logic signed [31:0]   scaled;
  logic signed [SW-1:0] s_cur, s_prev;
  logic                 hit, zc, arm_now, armed, rearm_ok;
  logic [TMW-1:0]       tmo_cnt;
  logic [RW-1:0]        num, den;

  cfd_delay_line #(.DW(DW), .DEPTH(MAX_DELAY), .SELW(SELW)) u_dline (
    .clk(clk), .rst(rst), .din(sample_in), .sel(dly_sel),
    .now_q(x_now), .dly_q(x_del)
  );

  always_comb begin
    scaled = cf_scale(32'(x_now));
    s_cur  = SW'(x_del) - signed'(scaled[SW-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) s_prev <= '0;
    else     s_prev <= s_cur;
  end

  cfd_arm_ctrl #(.DW(DW), .SW(SW), .TOUT(TOUT), .TMW(TMW)) u_arm (
    .clk(clk), .rst(rst), .x_now(x_now), .thresh(thresh),
    .s_cur(s_cur), .s_prev(s_prev), .mode(mode),
    .hit(hit), .zc(zc), .arm_now(arm_now), .armed(armed),
    .rearm_ok(rearm_ok), .tmo_cnt(tmo_cnt), .num(num), .den(den)
  );

  cfd_interp #(.SW(SW), .FW(FW)) u_div (
    .clk(clk), .rst(rst), .start(hit), .num(num), .den(den),
    .done(strobe), .quo(frac)
  );
endmodule

// File: rtl/cfd_timer_chk.sv
module cfd_timer_chk #(
  parameter int TOUT = 255,
  parameter int TMW  = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [1:0]     mode,
  input logic           hit,
  input logic           zc,
  input logic           arm_now,
  input logic           armed,
  input logic           rearm_ok,
  input logic [TMW-1:0] tmo_cnt
);
  // R3: outside leading-edge mode an event needs an arm
  a_r3_needs_arm: assert property (@(posedge clk) disable iff (rst)
    (hit && mode != 2'b10) |-> (armed || arm_now));

  // R5: in reject mode every event is a real shaped crossing
  a_r5_srt_crossing: assert property (@(posedge clk) disable iff (rst)
    (hit && mode == 2'b01) |-> zc);

  // R6: leading-edge events occur only on the threshold sample
  a_r6_le_on_arm: assert property (@(posedge clk) disable iff (rst)
    (hit && mode == 2'b10) |-> arm_now);

  // R9: an event leaves the detector disarmed
  a_r9_disarm_after_hit: assert property (@(posedge clk) disable iff (rst)
    hit |=> !armed);

  // R9: arming only follows a return above threshold
  a_r9_rearm_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(rearm_ok));

  // R10: the arm expires at the end of its window
  a_r10_timeout: assert property (@(posedge clk) disable iff (rst)
    (armed && tmo_cnt == TMW'(TOUT - 1) && !hit && !arm_now) |=> !armed);
endmodule

bind cfd_timer cfd_timer_chk #(.TOUT(TOUT), .TMW(TMW)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .hit(hit), .zc(zc),
  .arm_now(arm_now), .armed(armed), .rearm_ok(rearm_ok), .tmo_cnt(tmo_cnt)
);

// File: tb/cfd_timer_test.sv
module cfd_timer_test;
  localparam int DW = 12;
  localparam int FW = 6;
  localparam int TO = 40;
  localparam int HN = 8192;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic signed [DW-1:0] sample_in = '0;
  logic signed [DW-1:0] thresh = -12'sd100;
  logic [5:0]           dly_sel = 6'd7;
  logic [1:0]           mode = 2'b00;
  logic                 strobe;
  logic [FW-1:0]        frac;

  int n_chk = 0, n_fail = 0;
  int n = 0, n_stb = 0, last_frac = 0, first_stb_n = -1;
  int hx [HN];
  int exp_stb [HN];
  int exp_frac [HN];
  int m_rok = 0, m_armed = 0, m_tmo = 0, m_sp = 0;

  always #10 clk = ~clk;

  cfd_timer #(.TOUT(TO)) uut (
    .clk(clk), .rst(rst), .sample_in(sample_in), .thresh(thresh),
    .dly_sel(dly_sel), .mode(mode), .strobe(strobe), .frac(frac)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int fdiv(input int a, input int b);
    int q = a / b;
    if ((a % b) != 0 && a < 0) q = q - 1;
    return q;
  endfunction

  function automatic int fifth(input int x);
    return fdiv(x, 8) + fdiv(x, 16) + fdiv(x, 128);
  endfunction

  // Reference of the requirements, evaluated once per sample
  task automatic model(input int x);
    int d = int'(dly_sel) + 1;
    int xd = (n - d >= 0) ? hx[n - d] : 0;
    int s = xd - fifth(x);
    int th = int'(thresh);
    int below = (x < th) ? 1 : 0;
    int arm_now = m_rok & below;
    int zc = (m_sp >= 0 && s < 0) ? 1 : 0;
    int late = (arm_now == 1 && s < 0 && zc == 0) ? 1 : 0;
    int hit;
    hx[n] = x;
    if (mode == 2'b10) hit = arm_now;
    else if (mode == 2'b01) hit = (m_armed | arm_now) & zc;
    else hit = ((m_armed | arm_now) & zc) | late;
    exp_stb[n]  = hit;
    exp_frac[n] = (hit == 1 && zc == 1 && mode != 2'b10) ? (64 * m_sp) / (m_sp - s) : 0;
    if (hit == 1) m_armed = 0;
    else if (arm_now == 1 && !(mode == 2'b01 && late == 1)) begin
      m_armed = 1; m_tmo = 0;
    end else if (m_armed == 1) begin
      if (m_tmo == TO - 1) m_armed = 0;
      else m_tmo++;
    end
    if (below == 0) m_rok = 1;
    else if (arm_now == 1) m_rok = 0;
    m_sp = s;
  endtask

  task automatic push(input int x);
    @(negedge clk);
    if (n - 1 - FW >= 0) begin
      int k = n - 1 - FW;
      if (strobe || exp_stb[k] != 0) begin
        check(int'(strobe) == exp_stb[k], "R8", int'(strobe), exp_stb[k]);
        check(int'(frac) == exp_frac[k], "R7", int'(frac), exp_frac[k]);
      end
    end
    if (strobe) begin
      n_stb++;
      last_frac = int'(frac);
      if (first_stb_n < 0) first_stb_n = n;
    end
    sample_in = DW'(x);
    model(x);
    n++;
  endtask

  task automatic idle(input int cnt);
    for (int i = 0; i < cnt; i++) push(0);
  endtask

  // kind: 0 step, 1 ramp, 2 double pulse, 3 long hold
  task automatic scenario(input string tag, input logic [1:0] md, input int th,
                          input int d, input int kind, input int amp,
                          input int exp_cnt, input int exp_fr, input int exp_lat);
    int base, start;
    idle(100);
    @(negedge clk);
    mode = md; thresh = DW'(th); dly_sel = 6'(d - 1);
    idle(100);
    base = n_stb; first_stb_n = -1; start = n;
    case (kind)
      0: for (int i = 0; i < d + 20; i++) push(-amp);
      1: begin
        for (int k = 1; k <= 40; k++) push(-20 * k);
        for (int i = 0; i < 20; i++) push(-800);
      end
      2: begin
        for (int i = 0; i < 12; i++) push(-amp);
        idle(12);
        for (int i = 0; i < 12; i++) push(-amp);
      end
      default: for (int i = 0; i < 150; i++) push(-amp);
    endcase
    idle(100 + FW);
    check(n_stb - base == exp_cnt, tag, n_stb - base, exp_cnt);
    if (exp_fr >= 0 && exp_cnt > 0) check(last_frac == exp_fr, tag, last_frac, exp_fr);
    if (exp_lat >= 0) check(first_stb_n - start == exp_lat, "R8", first_stb_n - start, exp_lat);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(strobe == 1'b0, "R1", int'(strobe), 0);
    check(frac == '0, "R1", int'(frac), 0);
    rst = 1'b0;
    @(negedge clk);
    check(strobe == 1'b0, "R1", int'(strobe), 0);
  endtask

  initial begin
    for (int i = 0; i < HN; i++) begin hx[i] = 0; exp_stb[i] = 0; exp_frac[i] = 0; end
    t_reset();
    // R2 R4 R7 R8: fast step, crossing D samples after the edge
    scenario("R2", 2'b00, -100, 8, 0, 1000, 1, 12, 8 + FW + 1);
    scenario("R7", 2'b00, -100, 3, 0, 500, 1, 12, -1);
    scenario("R4", 2'b11, -100, 5, 0, 2000, 1, 12, -1);
    // R5: fast step passes the reject mode
    scenario("R5", 2'b01, -100, 8, 0, 1000, 1, 12, -1);
    // R4 R5 R6: slow ramp arms after the shaped crossing
    scenario("R4", 2'b00, -300, 4, 1, 0, 1, 0, -1);
    scenario("R5", 2'b01, -300, 4, 1, 0, 0, -1, -1);
    scenario("R6", 2'b10, -300, 4, 1, 0, 1, 0, -1);
    scenario("R6", 2'b10, -100, 8, 0, 1000, 1, 0, 0 + FW + 1);
    // R3: pulse never reaches threshold
    scenario("R3", 2'b00, -1500, 8, 0, 1000, 0, -1, -1);
    // R9: held pulse gives one event, double pulse gives two
    scenario("R9", 2'b00, -100, 8, 3, 1000, 1, 12, -1);
    scenario("R9", 2'b00, -100, 8, 2, 1000, 2, 12, -1);
    // R10: crossing on the last sample of the window, then one past it
    scenario("R10", 2'b00, -100, TO, 0, 1000, 1, 12, -1);
    scenario("R10", 2'b00, -100, TO + 1, 0, 1000, 0, -1, -1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule